// File: doc/BRIEF.md
# Hot-Plug Port Sequencer with Quarantine

This block brings one pluggable-module port from an empty cage to a monitored, alarm-eligible state, and keeps the port contained when its management transactions start to fail. A raw presence line, a power-good input and a done/error handshake from an external bus transaction engine drive it. A single-cycle `tick` strobe paces all of its timers. It drives the port power enable, the active-low module reset, the low-power-mode pin and an identification-read request. It also raises a flag that says when alarm evaluation may trust the module's readings.

When a transaction fails, the sequencer walks a fixed recovery ladder. Each rung asks the external bus logic for one recovery action through `recovReq`/`recovStep`, waits a backoff that grows with the attempt number, and retries the transaction. When the ladder runs out, or when too many consecutive transactions have failed, the port is quarantined. A quarantined port is only probed at a slow rate, and a good probe restarts the whole bring-up. Every wait is bounded and the port reports `degraded` instead of holding anything, so a bad module cannot hold up the rest of the line card.

The presence, power-good and handshake inputs are expected to be synchronous to `clk` already.

Top module: `hotplug_port_seq`

## Requirements
- R1: Power stays off until presence has been high for T_PRESENT ticks without a break. A cycle with presence low restarts the count.
- R2: After power is enabled, reset stays asserted until power-good is seen and then held for T_SETTLE ticks. If power-good drops during settling, the sequencer goes back to waiting for power-good and the settle count restarts.
- R3: When reset is released, the low-power pin stays high and `idReq` is raised. It stays high until the engine reports the transaction done.
- R4: A successful identification read releases the low-power pin and starts a warm-up of T_WARMUP ticks. During warm-up `alarmOk` is low. After warm-up `alarmOk` goes high.
- R5: Recovery step codes are issued in the order 0 (transaction timeout), 1 (bus reset), 2 (SCL clocking), 3 (branch isolation). Each step is tried N_MAX times. A failure on the last attempt of step 3 quarantines the port.
- R6: After the k-th attempt of a step is issued (k counted from 1), the retry `idReq` rises exactly T_BACKOFF·k ticks later.
- R7: Each recovery action pulses `evtValid` for one cycle. The pulse carries `evtStep` equal to the step code and `evtCount` equal to the attempt number counted from 1. Entering quarantine pulses `evtValid` with `evtStep` = 4 and `evtCount` = the consecutive-failure count.
- R8: The M_FAIL-th consecutive failed transaction quarantines the port. A successful retry clears the count and the ladder, and returns to warm-up with `alarmOk` low.
- R9: While quarantined, `quarantined` and `degraded` are high and `alarmOk` is low. A probe `idReq` is raised every T_PROBE ticks. A failed probe emits no event and waits for the next probe slot.
- R10: A successful probe turns power off and restarts the full sequence from presence qualification, with the failure count cleared.
- R11: Presence going low in any state turns power off and asserts reset on the next cycle.
- R12: `degraded` is high exactly during recovery and quarantine. `recovReq` is a one-cycle pulse with `recovStep` equal to the step code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe, one cycle per timer unit |
| presentRaw | input | 1 | Module presence, unfiltered |
| powerGood | input | 1 | Port power-good |
| txnDone | input | 1 | Bus engine finished a transaction (one cycle) |
| txnErr | input | 1 | Qualifies txnDone as failed |
| pwrEn | output | 1 | Port power enable |
| resetN | output | 1 | Module reset, active low |
| lowPwr | output | 1 | Module low-power-mode pin |
| idReq | output | 1 | Request for the minimal identification read |
| alarmOk | output | 1 | Readings are alarm-eligible |
| quarantined | output | 1 | Port is quarantined |
| degraded | output | 1 | Port is recovering or quarantined |
| recovReq | output | 1 | One-cycle request for a bus recovery action |
| recovStep | output | 2 | Recovery action code, 0..3 |
| evtValid | output | 1 | Event pulse |
| evtStep | output | 3 | Event step code, 0..3 recovery, 4 quarantine |
| evtCount | output | EW | Attempt number or consecutive-failure count |

## Verification
Presence is driven with random bounce patterns mixed with random tick gaps. This separates counting of ticks from counting of cycles, and separates restart-on-bounce from pause-on-bounce. Directed power-good drops during settling check that the settle count restarts and does not resume. Long runs of failed transactions are driven on two configurations. In one, the consecutive-failure limit ends the ladder early. In the other, the ladder runs out first. Together they tell the two quarantine triggers apart, and they check step order, attempt numbering and the growing backoff. A single successful retry in the middle of a failure run shows that the count really clears. A failed probe followed by a good probe shows that quarantine stays quiet and then restarts the full bring-up.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [3:0] {
    ST_DETECT,
    ST_POWER,
    ST_SETTLE,
    ST_IDREAD,
    ST_WARMUP,
    ST_MONITOR,
    ST_REC_ISSUE,
    ST_REC_WAIT,
    ST_REC_RETRY,
    ST_QUAR_EVT,
    ST_QUAR_WAIT,
    ST_QUAR_PROBE
  } seqState_e;

  typedef enum logic [2:0] {
    TS_PRESENT,
    TS_SETTLE,
    TS_WARMUP,
    TS_BACKOFF,
    TS_PROBE
  } timSel_e;

  localparam logic [1:0] STEP_TIMEOUT = 2'd0;
  localparam logic [1:0] STEP_BUSRST  = 2'd1;
  localparam logic [1:0] STEP_SCLCLK  = 2'd2;
  localparam logic [1:0] STEP_ISOLATE = 2'd3;
  localparam logic [2:0] EVT_QUAR     = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic    timClr;
    timSel_e timSel;
    logic    failInc;
    logic    failClr;
    logic    attInc;
    logic    stepInc;
    logic    ladderClr;
  } dpCmd_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hps_dp.sv
module hps_dp
  import hps_pkg::*;
#(
  parameter int T_PRESENT = 4,
  parameter int T_SETTLE  = 3,
  parameter int T_WARMUP  = 5,
  parameter int T_BACKOFF = 2,
  parameter int T_PROBE   = 6,
  parameter int N_MAX     = 2,
  parameter int M_FAIL    = 6,
  parameter int EW        = 4,
  parameter int AW        = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  dpCmd_t        cmd,
  output logic          timerHit,
  output logic          failAtLimit,
  output logic          attLast,
  output logic          stepLast,
  output logic [1:0]    step,
  output logic [AW-1:0] attempt,
  output logic [EW-1:0] failCnt
);

  localparam int MAX_FIXED = maxOf(maxOf(T_PRESENT, T_SETTLE), maxOf(T_WARMUP, T_PROBE));
  localparam int MAX_TGT   = maxOf(MAX_FIXED, T_BACKOFF * N_MAX);
  localparam int TW        = $clog2(MAX_TGT + 1);

  logic [TW-1:0] timer;
  logic [TW-1:0] target;

  always_comb begin
    unique case (cmd.timSel)
      TS_PRESENT: target = TW'(T_PRESENT);
      TS_SETTLE:  target = TW'(T_SETTLE);
      TS_WARMUP:  target = TW'(T_WARMUP);
      TS_BACKOFF: target = TW'(T_BACKOFF * (int'(attempt) + 1));
      TS_PROBE:   target = TW'(T_PROBE);
      default:    target = TW'(T_PRESENT);
    endcase
  end

  assign timerHit = tick && (timer == target - TW'(1));

  always_ff @(posedge clk) begin
    if (!rstN || cmd.timClr) timer <= '0;
    else if (tick)           timer <= timer + TW'(1);
  end

  // Consecutive failure counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN || cmd.failClr)                             failCnt <= '0;
    else if (cmd.failInc && (failCnt != {EW{1'b1}}))      failCnt <= failCnt + EW'(1);
  end

  assign failAtLimit = (failCnt == EW'(M_FAIL - 1));

  // Recovery ladder position
  always_ff @(posedge clk) begin
    if (!rstN || cmd.ladderClr) begin
      step    <= STEP_TIMEOUT;
      attempt <= '0;
    end else if (cmd.stepInc) begin
      step    <= step + 2'd1;
      attempt <= '0;
    end else if (cmd.attInc) begin
      attempt <= attempt + AW'(1);
    end
  end

  assign attLast  = (attempt == AW'(N_MAX - 1));
  assign stepLast = (step == STEP_ISOLATE);

endmodule

// File: rtl/hps_ctrl.sv
module hps_ctrl
  import hps_pkg::*;
#(
  parameter int EW = 4,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          presentRaw,
  input  logic          powerGood,
  input  logic          txnDone,
  input  logic          txnErr,
  input  logic          timerHit,
  input  logic          failAtLimit,
  input  logic          attLast,
  input  logic          stepLast,
  input  logic [1:0]    step,
  input  logic [AW-1:0] attempt,
  input  logic [EW-1:0] failCnt,
  output dpCmd_t        cmd,
  output logic          pwrEn,
  output logic          resetN,
  output logic          lowPwr,
  output logic          idReq,
  output logic          alarmOk,
  output logic          quarantined,
  output logic          degraded,
  output logic          recovReq,
  output logic [1:0]    recovStep,
  output logic          evtValid,
  output logic [2:0]    evtStep,
  output logic [EW-1:0] evtCount
);

  seqState_e state, nextState;
  logic okTxn, badTxn;

  assign okTxn  = txnDone && !txnErr;
  assign badTxn = txnDone && txnErr;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_DETECT;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '{timClr: 1'b0, timSel: TS_PRESENT, failInc: 1'b0, failClr: 1'b0,
                  attInc: 1'b0, stepInc: 1'b0, ladderClr: 1'b0};
    unique case (state)
      ST_DETECT: begin
        cmd.timSel = TS_PRESENT;
        if (!presentRaw)   cmd.timClr = 1'b1;
        else if (timerHit) nextState = ST_POWER;
      end
      ST_POWER: begin
        if (powerGood) nextState = ST_SETTLE;
      end
      ST_SETTLE: begin
        cmd.timSel = TS_SETTLE;
        if (!powerGood)    nextState = ST_POWER;
        else if (timerHit) nextState = ST_IDREAD;
      end
      ST_IDREAD, ST_WARMUP, ST_MONITOR: begin
        cmd.timSel = TS_WARMUP;
        if (okTxn) begin
          cmd.failClr = 1'b1;
          if (state == ST_IDREAD) nextState = ST_WARMUP;
        end else if (badTxn) begin
          cmd.failInc = 1'b1;
          nextState   = failAtLimit ? ST_QUAR_EVT : ST_REC_ISSUE;
        end else if (state == ST_WARMUP && timerHit) begin
          nextState = ST_MONITOR;
        end
      end
      ST_REC_ISSUE: begin
        nextState = ST_REC_WAIT;
      end
      ST_REC_WAIT: begin
        cmd.timSel = TS_BACKOFF;
        if (timerHit) nextState = ST_REC_RETRY;
      end
      ST_REC_RETRY: begin
        cmd.timSel = TS_BACKOFF;
        if (okTxn) begin
          cmd.failClr   = 1'b1;
          cmd.ladderClr = 1'b1;
          nextState     = ST_WARMUP;
        end else if (badTxn) begin
          cmd.failInc = 1'b1;
          if (failAtLimit) begin
            nextState = ST_QUAR_EVT;
          end else if (attLast) begin
            if (stepLast) begin
              nextState = ST_QUAR_EVT;
            end else begin
              cmd.stepInc = 1'b1;
              nextState   = ST_REC_ISSUE;
            end
          end else begin
            cmd.attInc = 1'b1;
            nextState  = ST_REC_ISSUE;
          end
        end
      end
      ST_QUAR_EVT: begin
        cmd.ladderClr = 1'b1;
        nextState     = ST_QUAR_WAIT;
      end
      ST_QUAR_WAIT: begin
        cmd.timSel = TS_PROBE;
        if (timerHit) nextState = ST_QUAR_PROBE;
      end
      ST_QUAR_PROBE: begin
        cmd.timSel = TS_PROBE;
        if (okTxn) begin
          cmd.failClr   = 1'b1;
          cmd.ladderClr = 1'b1;
          nextState     = ST_DETECT;
        end else if (badTxn) begin
          nextState = ST_QUAR_WAIT;
        end
      end
      default: nextState = ST_DETECT;
    endcase

    // Presence loss overrides everything
    if (state != ST_DETECT && !presentRaw) begin
      nextState     = ST_DETECT;
      cmd.failInc   = 1'b0;
      cmd.attInc    = 1'b0;
      cmd.stepInc   = 1'b0;
      cmd.failClr   = 1'b1;
      cmd.ladderClr = 1'b1;
    end
    if (nextState != state) cmd.timClr = 1'b1;
  end

  // Moore outputs
  always_comb begin
    pwrEn       = 1'b1;
    resetN      = 1'b1;
    lowPwr      = 1'b1;
    idReq       = 1'b0;
    alarmOk     = 1'b0;
    quarantined = 1'b0;
    degraded    = 1'b0;
    recovReq    = 1'b0;
    recovStep   = step;
    evtValid    = 1'b0;
    evtStep     = {1'b0, step};
    evtCount    = EW'(attempt) + EW'(1);
    unique case (state)
      ST_DETECT: begin
        pwrEn  = 1'b0;
        resetN = 1'b0;
      end
      ST_POWER, ST_SETTLE: resetN = 1'b0;
      ST_IDREAD:           idReq  = 1'b1;
      ST_WARMUP:           lowPwr = 1'b0;
      ST_MONITOR: begin
        lowPwr  = 1'b0;
        alarmOk = 1'b1;
      end
      ST_REC_ISSUE: begin
        degraded = 1'b1;
        recovReq = 1'b1;
        evtValid = 1'b1;
      end
      ST_REC_WAIT:  degraded = 1'b1;
      ST_REC_RETRY: begin
        degraded = 1'b1;
        idReq    = 1'b1;
      end
      ST_QUAR_EVT: begin
        degraded    = 1'b1;
        quarantined = 1'b1;
        evtValid    = 1'b1;
        evtStep     = EVT_QUAR;
        evtCount    = failCnt;
      end
      ST_QUAR_WAIT: begin
        degraded    = 1'b1;
        quarantined = 1'b1;
      end
      ST_QUAR_PROBE: begin
        degraded    = 1'b1;
        quarantined = 1'b1;
        idReq       = 1'b1;
      end
      default: begin
        pwrEn  = 1'b0;
        resetN = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/hotplug_port_seq.sv
module hotplug_port_seq
  import hps_pkg::*;
#(
  parameter int T_PRESENT = 4,
  parameter int T_SETTLE  = 3,
  parameter int T_WARMUP  = 5,
  parameter int T_BACKOFF = 2,
  parameter int T_PROBE   = 6,
  parameter int N_MAX     = 2,
  parameter int M_FAIL    = 6,
  localparam int EW = $clog2(maxOf(M_FAIL, 4 * N_MAX + 1) + 1),
  localparam int AW = $clog2(N_MAX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          presentRaw,
  input  logic          powerGood,
  input  logic          txnDone,
  input  logic          txnErr,
  output logic          pwrEn,
  output logic          resetN,
  output logic          lowPwr,
  output logic          idReq,
  output logic          alarmOk,
  output logic          quarantined,
  output logic          degraded,
  output logic          recovReq,
  output logic [1:0]    recovStep,
  output logic          evtValid,
  output logic [2:0]    evtStep,
  output logic [EW-1:0] evtCount
);

  dpCmd_t        cmd;
  logic          timerHit, failAtLimit, attLast, stepLast;
  logic [1:0]    step;
  logic [AW-1:0] attempt;
  logic [EW-1:0] failCnt;

  hps_dp #(
    .T_PRESENT(T_PRESENT), .T_SETTLE(T_SETTLE), .T_WARMUP(T_WARMUP),
    .T_BACKOFF(T_BACKOFF), .T_PROBE(T_PROBE), .N_MAX(N_MAX),
    .M_FAIL(M_FAIL), .EW(EW), .AW(AW)
  ) i_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .cmd(cmd),
    .timerHit(timerHit), .failAtLimit(failAtLimit), .attLast(attLast),
    .stepLast(stepLast), .step(step), .attempt(attempt), .failCnt(failCnt)
  );

  hps_ctrl #(.EW(EW), .AW(AW)) i_ctrl (
    .clk(clk), .rstN(rstN), .presentRaw(presentRaw), .powerGood(powerGood),
    .txnDone(txnDone), .txnErr(txnErr), .timerHit(timerHit),
    .failAtLimit(failAtLimit), .attLast(attLast), .stepLast(stepLast),
    .step(step), .attempt(attempt), .failCnt(failCnt), .cmd(cmd),
    .pwrEn(pwrEn), .resetN(resetN), .lowPwr(lowPwr), .idReq(idReq),
    .alarmOk(alarmOk), .quarantined(quarantined), .degraded(degraded),
    .recovReq(recovReq), .recovStep(recovStep), .evtValid(evtValid),
    .evtStep(evtStep), .evtCount(evtCount)
  );

endmodule

// File: rtl/hps_checker.sv
module hps_checker #(
  parameter int EW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          presentRaw,
  input logic          pwrEn,
  input logic          resetN,
  input logic          lowPwr,
  input logic          idReq,
  input logic          alarmOk,
  input logic          quarantined,
  input logic          degraded,
  input logic          recovReq,
  input logic          evtValid,
  input logic [2:0]    evtStep,
  input logic [EW-1:0] evtCount
);

  AST_PWR_AFTER_PRESENCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrEn) |-> $past(presentRaw)); // R1

  AST_RESET_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rstN)
    resetN |-> pwrEn); // R2

  AST_IDREQ_CONTEXT: assert property (@(posedge clk) disable iff (!rstN)
    idReq |-> (resetN && lowPwr && !alarmOk)); // R3

  AST_ALARM_CONTEXT: assert property (@(posedge clk) disable iff (!rstN)
    alarmOk |-> (pwrEn && resetN && !lowPwr && !degraded)); // R4

  AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> !evtValid); // R7

  AST_EVT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtStep <= 3'd4 && evtCount != '0)); // R7

  AST_QUAR_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    quarantined |-> (degraded && !alarmOk && pwrEn)); // R9

  AST_PRESENCE_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    !presentRaw |=> (!pwrEn && !resetN)); // R11

  AST_RECOV_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    recovReq |=> !recovReq); // R12

  AST_RECOV_DEGRADED: assert property (@(posedge clk) disable iff (!rstN)
    recovReq |-> (degraded && evtValid)); // R12

endmodule

bind hotplug_port_seq hps_checker #(.EW(EW)) i_hps_checker (
  .clk(clk), .rstN(rstN), .presentRaw(presentRaw), .pwrEn(pwrEn),
  .resetN(resetN), .lowPwr(lowPwr), .idReq(idReq), .alarmOk(alarmOk),
  .quarantined(quarantined), .degraded(degraded), .recovReq(recovReq),
  .evtValid(evtValid), .evtStep(evtStep), .evtCount(evtCount)
);

// File: tb/test_hotplug_port_seq.sv
`timescale 1ns/1ps
module test_hotplug_port_seq;

  localparam int TP = 4, TS = 3, TW = 5, TB = 2, TPR = 6, NM = 2, MF = 6, MF2 = 20;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic pres = 1'b0, pres2 = 1'b0, pg = 1'b0, txnDone = 1'b0, txnErr = 1'b0;

  logic pwrEn, resetN, lowPwr, idReq, alarmOk, quarantined, degraded, recovReq, evtValid;
  logic [1:0] recovStep;
  logic [2:0] evtStep;
  logic [3:0] evtCount;

  logic pwrEn2, resetN2, lowPwr2, idReq2, alarmOk2, quar2, degraded2, recovReq2, evtValid2;
  logic [1:0] recovStep2;
  logic [2:0] evtStep2;
  logic [4:0] evtCount2;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hotplug_port_seq #(.T_PRESENT(TP), .T_SETTLE(TS), .T_WARMUP(TW), .T_BACKOFF(TB),
                     .T_PROBE(TPR), .N_MAX(NM), .M_FAIL(MF)) i_hotplug_port_seq (
    .clk(clk), .rstN(rstN), .tick(tick), .presentRaw(pres), .powerGood(pg),
    .txnDone(txnDone), .txnErr(txnErr), .pwrEn(pwrEn), .resetN(resetN),
    .lowPwr(lowPwr), .idReq(idReq), .alarmOk(alarmOk), .quarantined(quarantined),
    .degraded(degraded), .recovReq(recovReq), .recovStep(recovStep),
    .evtValid(evtValid), .evtStep(evtStep), .evtCount(evtCount));

  hotplug_port_seq #(.T_PRESENT(TP), .T_SETTLE(TS), .T_WARMUP(TW), .T_BACKOFF(TB),
                     .T_PROBE(TPR), .N_MAX(NM), .M_FAIL(MF2)) i_hotplug_port_seq_ladder (
    .clk(clk), .rstN(rstN), .tick(tick), .presentRaw(pres2), .powerGood(pg),
    .txnDone(txnDone), .txnErr(txnErr), .pwrEn(pwrEn2), .resetN(resetN2),
    .lowPwr(lowPwr2), .idReq(idReq2), .alarmOk(alarmOk2), .quarantined(quar2),
    .degraded(degraded2), .recovReq(recovReq2), .recovStep(recovStep2),
    .evtValid(evtValid2), .evtStep(evtStep2), .evtCount(evtCount2));

  function automatic int expStep(input int f);
    return (f - 1) / NM;
  endfunction

  function automatic int expCnt(input int f);
    return (f - 1) % NM + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit t);
    tick = t;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1);
  endtask

  task automatic txn(input bit err);
    txnDone = 1'b1;
    txnErr  = err;
    @(negedge clk);
    txnDone = 1'b0;
    txnErr  = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    int run;
    int prevCnt;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 reset pwrEn", pwrEn, 0);
    check("R1 reset resetN", resetN, 0);
    check("R1 reset lowPwr", lowPwr, 1);
    check("R12 reset degraded", degraded, 0);
    check("R7 reset evtValid", evtValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 qualification with a bounce
    pres = 1'b1; pg = 1'b0;
    ticks(TP - 1);
    check("R1 not yet qualified", pwrEn, 0);
    pres = 1'b0; cyc(1'b0); pres = 1'b1;
    ticks(TP - 1);
    check("R1 bounce restarts count", pwrEn, 0);
    ticks(1);
    check("R1 qualified power", pwrEn, 1);
    check("R2 reset held at power-on", resetN, 0);

    // R2 power-good and settle
    ticks(3);
    check("R2 waiting for power-good", resetN, 0);
    pg = 1'b1; cyc(1'b0);
    ticks(TS - 1);
    check("R2 settle in progress", resetN, 0);
    pg = 1'b0; cyc(1'b0); pg = 1'b1; cyc(1'b0);
    ticks(TS - 1);
    check("R2 settle restarted", resetN, 0);
    ticks(1);
    check("R2 reset released", resetN, 1);
    check("R3 low-power held", lowPwr, 1);
    check("R3 id request", idReq, 1);
    repeat (3) cyc(1'b0);
    check("R3 id request held", idReq, 1);

    // R4 warm-up
    txn(1'b0);
    check("R4 low-power released", lowPwr, 0);
    check("R4 id request dropped", idReq, 0);
    ticks(TW - 1);
    check("R4 alarm gated in warm-up", alarmOk, 0);
    ticks(1);
    check("R4 alarm eligible", alarmOk, 1);

    // R8 one failure then successful retry
    txn(1'b1);
    check("R12 recovReq pulse", recovReq, 1);
    check("R12 recovStep", recovStep, 0);
    check("R7 event valid", evtValid, 1);
    check("R7 event step", evtStep, 0);
    check("R7 event count", evtCount, 1);
    check("R12 degraded in recovery", degraded, 1);
    cyc(1'b0);
    check("R12 recovReq one cycle", recovReq, 0);
    ticks(TB - 1);
    check("R6 backoff not elapsed", idReq, 0);
    ticks(1);
    check("R6 retry after backoff", idReq, 1);
    txn(1'b0);
    check("R8 retry ok back to warm-up", alarmOk, 0);
    check("R8 retry ok not degraded", degraded, 0);
    ticks(TW);
    check("R4 alarm eligible again", alarmOk, 1);

    // R5/R8 failure run to quarantine by count
    txn(1'b1);
    check("R5 first step", evtStep, 0);
    check("R8 count cleared by success", evtCount, 1);
    prevCnt = 1;
    for (int f = 2; f <= MF; f++) begin
      cyc(1'b0);
      ticks(TB * prevCnt - 1);
      check("R6 backoff grows", idReq, 0);
      ticks(1);
      check("R6 retry issued", idReq, 1);
      txn(1'b1);
      if (f < MF) begin
        check("R5 step order", evtStep, expStep(f));
        check("R12 recovStep matches", recovStep, expStep(f));
        check("R7 attempt count", evtCount, expCnt(f));
        prevCnt = expCnt(f);
      end else begin
        check("R8 quarantine event", evtStep, 4);
        check("R7 quarantine count", evtCount, MF);
        check("R9 quarantined", quarantined, 1);
        check("R12 no recovery at quarantine", recovReq, 0);
      end
    end

    // R9 probing
    cyc(1'b0);
    check("R9 event pulse ended", evtValid, 0);
    check("R9 degraded", degraded, 1);
    check("R9 alarm low", alarmOk, 0);
    ticks(TPR - 1);
    check("R9 no probe early", idReq, 0);
    ticks(1);
    check("R9 probe issued", idReq, 1);
    txn(1'b1);
    check("R9 failed probe no event", evtValid, 0);
    check("R9 still quarantined", quarantined, 1);
    ticks(TPR);
    check("R9 second probe", idReq, 1);

    // R10 good probe restarts
    txn(1'b0);
    check("R10 power dropped", pwrEn, 0);
    check("R10 quarantine left", quarantined, 0);
    ticks(TP);
    check("R10 requalified", pwrEn, 1);
    cyc(1'b0);
    ticks(TS);
    check("R10 id read again", idReq, 1);
    txn(1'b0);
    ticks(TW);
    txn(1'b1);
    check("R10 failure count cleared", evtStep, 0);
    check("R10 attempt restarts", evtCount, 1);

    // R11 presence loss during recovery
    cyc(1'b0);
    pres = 1'b0; cyc(1'b0);
    check("R11 power off", pwrEn, 0);
    check("R11 reset asserted", resetN, 0);
    check("R12 degraded cleared", degraded, 0);

    // R1/R11 random presence and tick patterns
    for (int trial = 0; trial < 25; trial++) begin
      pres = 1'b0; cyc(1'b0);
      check("R11 detect after drop", pwrEn, 0);
      run = 0;
      for (int c = 0; c < 300 && run < TP; c++) begin
        bit p, t;
        p = ($urandom % 6) != 0;
        t = $urandom % 2;
        pres = p;
        cyc(t);
        if (!p) run = 0;
        else if (t) run++;
        check("R1 random qualification", pwrEn, (run >= TP) ? 1 : 0);
      end
    end
    pres = 1'b0; cyc(1'b0);

    // R5 ladder exhaustion on second configuration
    pres2 = 1'b1;
    ticks(TP);
    cyc(1'b0);
    ticks(TS);
    check("R3 ladder unit id request", idReq2, 1);
    txn(1'b0);
    ticks(TW);
    check("R4 ladder unit monitoring", alarmOk2, 1);
    txn(1'b1);
    check("R5 ladder step 0", evtStep2, 0);
    prevCnt = 1;
    for (int f = 2; f <= 4 * NM + 1; f++) begin
      cyc(1'b0);
      ticks(TB * prevCnt);
      txn(1'b1);
      if (f <= 4 * NM) begin
        check("R5 ladder step order", evtStep2, expStep(f));
        check("R5 ladder attempt", evtCount2, expCnt(f));
        prevCnt = expCnt(f);
      end else begin
        check("R5 ladder exhausted quarantine", evtStep2, 4);
        check("R5 ladder quarantine count", evtCount2, 4 * NM + 1);
        check("R5 ladder quarantined", quar2, 1);
      end
    end
    pres2 = 1'b0; cyc(1'b0);
    check("R11 ladder unit off", pwrEn2, 0);

    finish();
  end

endmodule